// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block picks which of the DMA channel requests is served next. It is sized by a group parameter `GRP`, and the channel count is twice `GRP`. Each cycle it looks at the request vector and the current priority order, and it raises a one-hot grant with a valid flag. The grant is combinational, so it appears in the same cycle as the requests. The transfer engine reports each finished transfer with a one-cycle `xfer_end` pulse and the channel number. The register logic reports any write of the priority mode bits with `mode_wr`.

Three orderings are available. Fixed order 1 ranks the channels in ascending number. Fixed order 2 interleaves the lower group with the upper group. The third ordering rotates only the lower group of channels. A channel of that group that finishes a transfer drops to last place within the group. The upper group always stays below the lower group, in ascending order. Any write of the mode bits returns the rotation to its starting point.

Top module: `dma_prio_arb`

## Requirements
- R1: With `mode` = 2'b00 or 2'b11 (fixed order 1), the grant goes to the lowest-numbered requesting channel.
- R2: With `mode` = 2'b01 (fixed order 2), the order is ch0, ch4, ch1, ch5, ch2, ch6, ch3, ch7. In general this is lower-group channel k followed by upper-group channel GRP+k.
- R3: With `mode` = 2'b10 (rotating), an `xfer_end` on channel c < GRP with `mode_wr` low makes the order of the lower group start at c+1 (modulo GRP) and end at c. For example, after an end on channel 1 the order is 2,3,0,1,4,5,6,7.
- R4: In rotating mode every requesting lower-group channel outranks all upper-group channels. The upper-group channels rank among themselves in ascending order.
- R5: An `xfer_end` on a channel ≥ GRP leaves the order unchanged.
- R6: A cycle with `mode_wr` high resets the rotation, so the order returns to 0,1,2,3,…. This takes precedence over an `xfer_end` in the same cycle.
- R7: When no channel requests, `grant` is all zeros and `grant_valid` is 0. Otherwise `grant` is one-hot on a requesting channel and `grant_valid` is 1.
- R8: The grant follows `req` in the same cycle. A change of order takes effect only after the clock edge on which `xfer_end` or `mode_wr` was sampled.
- R9: After reset the rotation is at its starting point, 0,1,2,3.
- R10: An `xfer_end` while `mode` is not 2'b10 leaves the rotation unchanged. It is visible once `mode` becomes 2'b10 without a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 2*GRP | Channel request vector |
| mode | input | 2 | Priority mode select |
| mode_wr | input | 1 | Mode bits written this cycle |
| xfer_end | input | 1 | Transfer finished this cycle |
| end_ch | input | $clog2(2*GRP) | Channel whose transfer finished |
| grant | output | 2*GRP | One-hot grant |
| grant_valid | output | 1 | A grant is present |

## Verification
The bench builds the block with GRP = 4, which gives the eight-channel case. With eight channels, both fixed orders, all four rotation positions and every end channel, including the upper channels that must leave the order alone, can be reached within a few thousand cycles. A queue-based model rotates its list of lower channels until the finished channel sits last. The bench compares the grant and the valid flag against this model on every cycle. This happens under directed sequences and under random requests, mode writes and mode changes without a write.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int GRP = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2*GRP-1:0]             req,
  input  logic [1:0]                   mode,
  input  logic                         mode_wr,
  input  logic                         xfer_end,
  input  logic [$clog2(2*GRP)-1:0]     end_ch,
  output logic [2*GRP-1:0]             grant,
  output logic                         grant_valid
);
  localparam int N  = 2 * GRP;
  localparam int CW = $clog2(N);
  localparam int RW = (GRP > 1) ? $clog2(GRP) : 1;
  localparam logic [1:0] M_FIX1 = 2'b00;
  localparam logic [1:0] M_FIX2 = 2'b01;
  localparam logic [1:0] M_ROT  = 2'b10;

  logic [RW-1:0] rr_top;
  logic          low_end;
  logic [RW-1:0] end_low;
  logic [RW-1:0] rr_next;

  assign low_end = int'(end_ch) < GRP;
  assign end_low = end_ch[RW-1:0];
  assign rr_next = (int'(end_low) == GRP - 1) ? '0 : end_low + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 rr_top <= '0;
    else if (mode_wr)                           rr_top <= '0;
    else if (xfer_end && mode == M_ROT && low_end) rr_top <= rr_next;
  end

  function automatic int chan_at(input int p, input logic [1:0] m, input int top);
    if (m == M_FIX2)      return (p % 2 == 0) ? p / 2 : GRP + p / 2;
    else if (m == M_ROT)  return (p < GRP) ? (top + p) % GRP : p;
    else                  return p;
  endfunction

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int p = 0; p < N; p++) begin
      int c;
      c = chan_at(p, mode, int'(rr_top));
      if (!found && req[c]) begin
        grant[c] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign grant_valid = |grant;

  // R7
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  p_valid_r7:  assert property (@(posedge clk) disable iff (!rst_n) grant_valid == (|req));
  p_subset_r7: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == '0);
  // R1
  p_fix1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ROT && mode != M_FIX2 && req[0]) |-> grant[0]);
  // R2
  p_fix2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FIX2 && !req[0] && req[GRP]) |-> grant[GRP]);
  // R4
  p_lowgrp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ROT && (|req[GRP-1:0])) |-> (|grant[GRP-1:0]));
  // R6
  p_wrreset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_wr) && mode == M_ROT && req[0]) |-> grant[0]);
  // R3
  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_end && !mode_wr && mode == M_ROT && low_end) && mode == M_ROT && (&req[GRP-1:0]))
      |-> grant == (N'(1) << ((int'($past(end_ch)) + 1) % GRP)));
  // R5
  p_hiend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !mode_wr && !low_end) |=> $stable(rr_top));
endmodule

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;
  localparam int GRP = 4;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic [1:0] mode = 2'b00;
  logic mode_wr = 0, xfer_end = 0;
  logic [2:0] end_ch = '0;
  logic [N-1:0] grant;
  logic grant_valid;

  int total = 0, bad = 0, cycles = 0;
  int low_q[$];

  always #5 clk = ~clk;

  dma_prio_arb #(.GRP(GRP)) dut (.clk, .rst_n, .req, .mode, .mode_wr,
    .xfer_end, .end_ch, .grant, .grant_valid);

  function automatic void order_list(output int ol[8]);
    int k = 0;
    if (mode == 2'b01) begin
      int a[8] = '{0, 4, 1, 5, 2, 6, 3, 7};
      ol = a;
    end else if (mode == 2'b10) begin
      foreach (low_q[i]) begin ol[k] = low_q[i]; k++; end
      for (int c = 4; c < 8; c++) begin ol[k] = c; k++; end
    end else begin
      for (int c = 0; c < 8; c++) ol[c] = c;
    end
  endfunction

  function automatic logic [N-1:0] expect_grant();
    int ol[8];
    order_list(ol);
    for (int i = 0; i < 8; i++) if (req[ol[i]]) return N'(1) << ol[i];
    return '0;
  endfunction

  task automatic check(input string tag);
    logic [N-1:0] eg;
    eg = expect_grant();
    total++;
    if (grant !== eg || grant_valid !== (eg != 0)) begin
      bad++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b", tag, grant, grant_valid, eg, eg != 0);
    end
  endtask

  task automatic model_edge();
    if (!rst_n || mode_wr) low_q = '{0, 1, 2, 3};
    else if (xfer_end && mode == 2'b10 && end_ch < 4)
      while (low_q[$] != int'(end_ch)) low_q.push_back(low_q.pop_front());
  endtask

  // drive after negedge, check, then advance one edge
  task automatic step(input logic [N-1:0] r, input logic [1:0] m, input logic w,
                      input logic e, input int ch, input string tag);
    req = r; mode = m; mode_wr = w; xfer_end = e; end_ch = 3'(ch);
    #1 check(tag);
    @(posedge clk); model_edge();
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    bad++;
    $display("FAIL watchdog: cycles=%0d expected < 200000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    low_q = '{0, 1, 2, 3};
    @(negedge clk); step('0, 2'b00, 0, 0, 0, "R9 reset");
    @(negedge clk); rst_n = 1;
    step('0, 2'b10, 0, 0, 0, "R7 idle");
    step(8'hFF, 2'b10, 0, 0, 0, "R9 rot start");
    step(8'hAA, 2'b00, 0, 0, 0, "R1 fix1");
    step(8'hF0, 2'b11, 0, 0, 0, "R1 mode11");
    step(8'hF0, 2'b01, 1, 0, 0, "R2 fix2 upper");
    step(8'h24, 2'b01, 0, 0, 0, "R2 fix2 mix");
    step(8'h0F, 2'b10, 1, 0, 0, "R8 wr to rot");
    step(8'h0F, 2'b10, 0, 1, 1, "R8 same cycle");
    step(8'h0F, 2'b10, 0, 0, 0, "R3 after end ch1");
    step(8'h0B, 2'b10, 0, 0, 0, "R3 order 2301");
    step(8'hF0, 2'b10, 0, 1, 5, "R4 upper only");
    step(8'h0F, 2'b10, 0, 0, 0, "R5 hi end kept");
    step(8'hF1, 2'b10, 0, 0, 0, "R4 low beats high");
    step(8'h0F, 2'b10, 1, 1, 3, "R6 wr vs end");
    step(8'h0F, 2'b10, 0, 0, 0, "R6 reset order");
    step(8'h0F, 2'b00, 0, 1, 0, "R10 end in fix");
    step(8'h0F, 2'b10, 0, 0, 0, "R10 no rotate");
    step(8'h0F, 2'b10, 0, 1, 3, "R3 end ch3");
    step(8'h0F, 2'b10, 0, 0, 0, "R3 wrap");
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      logic w;
      m = (($urandom % 8) == 0) ? 2'($urandom) : mode;
      w = (m != mode) ? (($urandom % 4) != 0) : (($urandom % 50) == 0);
      step(8'($urandom) & 8'($urandom), m, w, ($urandom % 3) == 0, $urandom % 8,
           m == 2'b10 ? "R3 rand rot" : (m == 2'b01 ? "R2 rand" : "R1 rand"));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule